// File: doc/BRIEF.md
# Slave Address Recognizer with General-Call Option

This block decides whether a bus transfer is addressed to this node while it acts as a slave. After each START condition, the first byte delivered by the byte shifter is compared with a programmable 7-bit node address. As an option, the all-zero broadcast address in write direction is also accepted. The outcome (ACK or NACK) is handed to the acknowledge logic through a one-entry valid/ready channel. A match also raises a one-cycle interrupt request and sets a two-bit status code that tells a node-address hit apart from a broadcast hit.

The configuration byte is written over a plain CPU port. Bits 7 to 1 hold the node address. Bit 0 enables broadcast recognition. The received byte uses the same layout: bits 7 to 1 carry the address and bit 0 carries the direction, where 0 means write and 1 means read.

The address input is a valid/ready stream. `addr_ready` is high whenever no decision is waiting at the output. While the acknowledge logic holds `ack_ready` low, a pending decision blocks new address bytes. A byte is taken on a clock edge where `addr_valid` and `addr_ready` are both high. When the block is not armed, or is not in slave mode, it takes bytes and discards them. A START in the same cycle as a handshake wins: that byte is dropped, and the next byte is the one compared.

Top module: `addr_match`

## Requirements
- R1: After reset, `cfg_rdata` is 0xFE (address all ones, broadcast disabled), `ack_valid` and `irq` are 0, `match_kind` is 0, and `addr_ready` is 1.
- R2: A write on `cfg_we` is visible on `cfg_rdata` one cycle later. Bits 7:1 are the node address and bit 0 is the broadcast enable.
- R3: When armed, a byte whose bits 7:1 equal a nonzero configured address produces a decision with `ack_yes`=1 and `match_kind`=1, whatever the direction bit.
- R4: When broadcast is enabled, the byte 0x00 produces `ack_yes`=1 and `match_kind`=2. An address field of zero is never treated as a node-address match.
- R5: When broadcast is disabled, the byte 0x00 produces `ack_yes`=0. Every NACK decision leaves `match_kind`=0.
- R6: The byte 0x01 (broadcast with read direction) produces `ack_yes`=0, even with broadcast enabled.
- R7: `irq` is high for exactly one cycle, the cycle after an accepted compare that produced ACK. It is never high for a NACK.
- R8: Only the first byte after a START is compared. Later bytes are taken and produce no decision until the next START.
- R9: While `slave_mode` is 0, START is ignored and bytes produce no decision and no `irq`.
- R10: While `ack_valid` is 1 and `ack_ready` is 0, the decision holds stable and `addr_ready` is 0. `ack_valid` falls on the edge where `ack_ready` is 1.
- R11: `start_det` clears `match_kind` to 0. Otherwise `match_kind` keeps its value between compares.
- R12: If a byte handshake coincides with `start_det`, that byte is dropped and the following byte is compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Current configuration byte |
| slave_mode | input | 1 | 1 when the bus controller operates as slave |
| start_det | input | 1 | One-cycle START condition pulse |
| addr_valid | input | 1 | Received byte valid |
| addr_ready | output | 1 | Block can take a received byte |
| addr_byte | input | 8 | Received byte (bits 7:1 address, bit 0 direction) |
| ack_valid | output | 1 | Decision pending for the acknowledge logic |
| ack_ready | input | 1 | Acknowledge logic takes the decision |
| ack_yes | output | 1 | 1 = answer ACK, 0 = answer NACK |
| irq | output | 1 | One-cycle interrupt request on a match |
| match_kind | output | 2 | 0 none, 1 node address, 2 broadcast |

## Verification
Several properties are checked on every cycle: a pending decision stays stable under back-pressure, `irq` lasts one cycle and only comes with an ACK, a NACK always carries the status code 0, slave-mode-off never creates a decision, a decision only follows an armed compare, and configuration writes take effect. The truth table of the compare (direction bit, broadcast enable, the zero address, read-direction broadcast) and the reset value are covered by the bench's vector table. Ordering effects need the bench's directed scenarios: bytes after the first following a START, a START colliding with a handshake, status clearing on START, and leaving and re-entering slave mode.

// File: rtl/addr_match_pkg.sv
package addr_match_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = ADDR_W + 1;

  typedef enum logic [1:0] {
    MK_NONE  = 2'd0,
    MK_OWN   = 2'd1,
    MK_GCALL = 2'd2
  } match_kind_e;
endpackage

// File: rtl/addr_cfg_reg.sv
module addr_cfg_reg #(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] RESET_VAL = 8'hFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic [BYTE_W-2:0] node_addr,
  output logic              bcast_en
);
  logic [BYTE_W-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= RESET_VAL;
    else if (we) cfg_q <= wdata;
  end

  assign rdata     = cfg_q;
  assign node_addr = cfg_q[BYTE_W-1:1];
  assign bcast_en  = cfg_q[0];

  // R2: a write lands in the register on the next edge
  p_cfg_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rdata == $past(wdata)));
endmodule

// File: rtl/addr_compare.sv
module addr_compare #(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W:0]   rx_byte,
  input  logic [ADDR_W-1:0] node_addr,
  input  logic              bcast_en,
  output logic              node_hit,
  output logic              bcast_hit
);
  logic [ADDR_W-1:0] rx_addr;
  logic              rx_read;
  logic              rx_zero;

  always_comb begin
    rx_addr   = rx_byte[ADDR_W:1];
    rx_read   = rx_byte[0];
    rx_zero   = (rx_addr == '0);
    // address field zero is reserved for broadcast and never a node hit
    node_hit  = !rx_zero && (rx_addr == node_addr);
    // broadcast only counts in write direction
    bcast_hit = bcast_en && rx_zero && !rx_read;
  end
endmodule

// File: rtl/match_ctrl.sv
module match_ctrl
  import addr_match_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slave_mode,
  input  logic        start_det,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic        node_hit,
  input  logic        bcast_hit,
  output logic        dec_valid,
  input  logic        dec_ready,
  output logic        dec_ack,
  output match_kind_e kind,
  output logic        irq
);
  logic armed_q;
  logic take;
  logic evaluate;
  logic hit;

  assign in_ready = !dec_valid;
  assign take     = in_valid && in_ready;
  assign evaluate = take && armed_q && slave_mode && !start_det;
  assign hit      = node_hit || bcast_hit;

  // arm once per START, disarm on the first byte taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        armed_q <= 1'b0;
    else if (start_det && slave_mode)  armed_q <= 1'b1;
    else if (take || !slave_mode)      armed_q <= 1'b0;
  end

  // one-entry decision holding register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_ack   <= 1'b0;
    end else if (evaluate) begin
      dec_valid <= 1'b1;
      dec_ack   <= hit;
    end else if (dec_ready) begin
      dec_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         kind <= MK_NONE;
    else if (start_det) kind <= MK_NONE;
    else if (evaluate) begin
      if (bcast_hit)     kind <= MK_GCALL;
      else if (node_hit) kind <= MK_OWN;
      else               kind <= MK_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= evaluate && hit;
  end

  // R10: pending decision holds under back-pressure
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready && !start_det) |=>
      (dec_valid && $stable(dec_ack) && $stable(kind)));

  // R7: interrupt is a single-cycle pulse
  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R7: interrupt only alongside an ACK decision
  p_irq_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (dec_valid && dec_ack));

  // R5: a NACK never reports a match kind
  p_nack_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ack) |-> (kind == MK_NONE));

  // R9: no new decision while not in slave mode
  p_master_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && !dec_valid) |=> !dec_valid);

  // R8: a decision only follows an armed compare
  p_armed_eval_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_valid) |-> $past(armed_q));
endmodule

// File: rtl/addr_match.sv
module addr_match
  import addr_match_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CFG_RESET = 8'hFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [BYTE_W-1:0] cfg_wdata,
  output logic [BYTE_W-1:0] cfg_rdata,
  input  logic              slave_mode,
  input  logic              start_det,
  input  logic              addr_valid,
  output logic              addr_ready,
  input  logic [BYTE_W-1:0] addr_byte,
  output logic              ack_valid,
  input  logic              ack_ready,
  output logic              ack_yes,
  output logic              irq,
  output logic [1:0]        match_kind
);
  logic [ADDR_W-1:0] node_addr;
  logic              bcast_en;
  logic              node_hit;
  logic              bcast_hit;
  match_kind_e       kind;

  addr_cfg_reg #(
    .BYTE_W   (BYTE_W),
    .RESET_VAL(CFG_RESET)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .wdata    (cfg_wdata),
    .rdata    (cfg_rdata),
    .node_addr(node_addr),
    .bcast_en (bcast_en)
  );

  addr_compare #(
    .ADDR_W(ADDR_W)
  ) u_cmp (
    .rx_byte  (addr_byte),
    .node_addr(node_addr),
    .bcast_en (bcast_en),
    .node_hit (node_hit),
    .bcast_hit(bcast_hit)
  );

  match_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .slave_mode(slave_mode),
    .start_det (start_det),
    .in_valid  (addr_valid),
    .in_ready  (addr_ready),
    .node_hit  (node_hit),
    .bcast_hit (bcast_hit),
    .dec_valid (ack_valid),
    .dec_ready (ack_ready),
    .dec_ack   (ack_yes),
    .kind      (kind),
    .irq       (irq)
  );

  assign match_kind = kind;
endmodule

// File: tb/addr_match_test.sv
module addr_match_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       slave_mode = 1'b1;
  logic       start_det = 1'b0;
  logic       addr_valid = 1'b0;
  logic       addr_ready;
  logic [7:0] addr_byte = 8'h00;
  logic       ack_valid;
  logic       ack_ready = 1'b1;
  logic       ack_yes;
  logic       irq;
  logic [1:0] match_kind;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  addr_match uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .slave_mode(slave_mode), .start_det(start_det),
    .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_byte(addr_byte),
    .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_yes(ack_yes),
    .irq(irq), .match_kind(match_kind)
  );

  typedef struct packed {
    logic [7:0] cfg;
    logic [7:0] rx;
    logic       ack;
    logic [1:0] kind;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{8'hA4, 8'hA4, 1'b1, 2'd1},  // R3 write dir
    '{8'hA4, 8'hA5, 1'b1, 2'd1},  // R3 read dir
    '{8'hA4, 8'hA6, 1'b0, 2'd0},  // R5 mismatch
    '{8'hA5, 8'h00, 1'b1, 2'd2},  // R4 broadcast
    '{8'hA4, 8'h00, 1'b0, 2'd0},  // R5 broadcast off
    '{8'hA5, 8'h01, 1'b0, 2'd0},  // R6 broadcast read
    '{8'h01, 8'h00, 1'b1, 2'd2},  // R4 zero address, broadcast on
    '{8'h00, 8'h00, 1'b0, 2'd0},  // R4 zero address never node hit
    '{8'hFF, 8'hFE, 1'b1, 2'd1},  // R3
    '{8'hFF, 8'h01, 1'b0, 2'd0}   // R6
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_det = 1'b1;
    @(negedge clk); start_det = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); addr_valid = 1'b1; addr_byte = b;
    while (!addr_ready) @(negedge clk);
    @(negedge clk); addr_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 cfg_rdata", cfg_rdata, 8'hFE);
    check("R1 ack_valid", ack_valid, 0);
    check("R1 irq", irq, 0);
    check("R1 match_kind", match_kind, 0);
    check("R1 addr_ready", addr_ready, 1);

    // R1 reset address 0x7F, broadcast off
    pulse_start(); send_byte(8'hFE);
    check("R1 R3 reset addr ack", {ack_valid, ack_yes}, 2'b11);
    pulse_start(); send_byte(8'h00);
    check("R1 R5 reset broadcast off", {ack_valid, ack_yes}, 2'b10);

    // vector table
    for (int i = 0; i < NV; i++) begin
      cfg_write(VEC[i].cfg);
      check("R2 cfg readback", cfg_rdata, VEC[i].cfg);
      pulse_start();
      send_byte(VEC[i].rx);
      check("R3 R4 R5 R6 ack_valid", ack_valid, 1);
      check("R3 R4 R5 R6 ack_yes", ack_yes, VEC[i].ack);
      check("R3 R4 R5 R6 match_kind", match_kind, VEC[i].kind);
      check("R7 irq", irq, VEC[i].ack);
      @(negedge clk);
      check("R7 irq one cycle", irq, 0);
      check("R10 ack drops with ack_ready", ack_valid, 0);
    end

    // R8: second byte after a START is not compared
    cfg_write(8'hA4);
    pulse_start(); send_byte(8'hA4);
    check("R8 first byte", ack_yes, 1);
    send_byte(8'hA4);
    check("R8 second byte no decision", ack_valid, 0);
    check("R8 second byte no irq", irq, 0);
    // R11: status held, then cleared by START
    check("R11 kind held", match_kind, 1);
    pulse_start();
    check("R11 kind cleared", match_kind, 0);

    // R10 back-pressure
    ack_ready = 1'b0;
    send_byte(8'hA4);
    check("R10 pending", {ack_valid, ack_yes, addr_ready}, 3'b110);
    @(negedge clk); addr_valid = 1'b1; addr_byte = 8'hA4;
    repeat (3) @(negedge clk);
    check("R10 held", {ack_valid, ack_yes, addr_ready}, 3'b110);
    check("R10 kind held", match_kind, 1);
    ack_ready = 1'b1;
    @(negedge clk);
    check("R10 released", {ack_valid, addr_ready}, 2'b01);
    @(negedge clk); addr_valid = 1'b0;
    check("R8 R10 late byte dropped", ack_valid, 0);

    // R9 slave mode off
    slave_mode = 1'b0;
    pulse_start(); send_byte(8'hA4);
    check("R9 no decision", ack_valid, 0);
    check("R9 no irq", irq, 0);
    slave_mode = 1'b1;
    pulse_start();
    @(negedge clk); slave_mode = 1'b0;
    send_byte(8'hA4);
    check("R9 disarmed by mode drop", ack_valid, 0);
    slave_mode = 1'b1;
    pulse_start(); send_byte(8'hA4);
    check("R9 recovers", {ack_valid, ack_yes}, 2'b11);

    // R12 START collides with handshake
    @(negedge clk); start_det = 1'b1; addr_valid = 1'b1; addr_byte = 8'h10;
    @(negedge clk); start_det = 1'b0; addr_valid = 1'b0;
    check("R12 colliding byte dropped", ack_valid, 0);
    send_byte(8'hA4);
    check("R12 next byte compared", {ack_valid, ack_yes, irq}, 3'b111);

    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule